// File: doc/BRIEF.md
# PLL Digital Lock Detector

This block decides whether a phase-locked loop is locked by looking at the timing of the two rising edges that reach its phase-frequency detector. Both edges arrive as one-tick strobes in a fast measurement clock. The block pairs the first edge from either input with the next edge on the other input. It measures the distance between them in ticks and compares that gap with two thresholds. The thresholds come from a window-select bit and a two-bit anti-backlash code.

A PFD cycle whose gap is below the lock threshold is good. One whose gap is above the unlock threshold, or whose partner edge never arrives within the pairing timeout, is bad. Anything between the two thresholds is neutral. The lock flag rises only after a programmable run of consecutive good cycles and falls after a single bad cycle. Because the unlock threshold is wider than the lock threshold, a neutral gap neither builds lock nor breaks it, so the flag does not chatter.

Top module: `phase_lock_monitor`

## Requirements
- R1: A synchronous reset clears `locked` and `phaseGap` to 0, restarts the good-cycle run and discards any edge still waiting for its partner.
- R2: The first edge on either input is paired with the next edge on the other input. The gap is the tick distance between them, and 0 when both strobes are high in the same tick. `phaseGap` shows it one cycle after the partner strobe.
- R3: While an edge is waiting for its partner, further strobes on the same input are ignored, so the gap is measured from the first of them.
- R4: The lock threshold is 4 ticks with `windowSel`=0 and 12 ticks with `windowSel`=1. The unlock threshold is 8 or 24 ticks. `backlashCode` (0..3) is added to both.
- R5: A gap strictly below the lock threshold is a good cycle. `locked` rises after a run of consecutive good cycles whose length is set by `countCode`: 0 gives 5, 1 gives 16, 2 gives 64 and 3 gives 255.
- R6: Any cycle that is not good restarts the run toward lock, including a neutral one.
- R7: While locked, a gap from the lock threshold up to and including the unlock threshold leaves `locked` high.
- R8: A single gap strictly greater than the unlock threshold clears `locked`.
- R9: If no partner edge arrives within `pairTimeout` ticks of the first edge, the cycle counts as bad, `phaseGap` becomes 16'hFFFF and the waiting edge is dropped.
- R10: `locked` reacts to a cycle's class one clock after `phaseGap` shows that cycle, that is two clocks after the partner strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Measurement clock; one tick per cycle |
| rst | input | 1 | Synchronous reset, active high |
| refEdge | input | 1 | One-tick strobe for a reference rising edge |
| fbEdge | input | 1 | One-tick strobe for a feedback rising edge |
| windowSel | input | 1 | Selects the narrow (0) or wide (1) threshold pair |
| backlashCode | input | 2 | Anti-backlash setting, added in ticks to both thresholds |
| countCode | input | 2 | Selects the good-cycle run length for lock |
| pairTimeout | input | 16 | Longest wait in ticks for a partner edge |
| locked | output | 1 | Lock indicator with hysteresis |
| phaseGap | output | 16 | Last measured gap in ticks (all ones after a timeout) |

## Verification
The gap of a pair is due on `phaseGap` at the first clock edge after the partner strobe is sampled. The lock flag answers to that same cycle one clock edge later. A timeout shows up one edge after the tick in which the wait reaches `pairTimeout`. The bench keeps a behavioural reference model that follows exactly this timing and compares both outputs at every falling edge. Its directed checks are made at the falling edges that follow the due edge, or after a whole PFD period has passed, so that no check lands in the cycle where the value is still moving.

// File: rtl/plm_pkg.sv
package plm_pkg;

  // Classification strobes sent from the datapath to the lock control.
  typedef struct packed {
    logic good;   // gap below lock threshold
    logic mid;    // gap between the thresholds
    logic bad;    // gap above unlock threshold or partner missing
  } gap_evt_t;

  typedef enum logic [1:0] {
    PEND_NONE = 2'd0,
    PEND_REF  = 2'd1,
    PEND_FB   = 2'd2
  } pend_e;

  // Consecutive good cycles required for lock, per configuration code.
  function automatic logic [7:0] runTarget(input logic [1:0] code);
    case (code)
      2'd0:    runTarget = 8'd5;
      2'd1:    runTarget = 8'd16;
      2'd2:    runTarget = 8'd64;
      default: runTarget = 8'd255;
    endcase
  endfunction

endpackage

// File: rtl/plm_datapath.sv
module plm_datapath
  import plm_pkg::*;
#(
  parameter int GAP_W          = 16,
  parameter int LOCK_NARROW    = 4,
  parameter int UNLOCK_NARROW  = 8,
  parameter int LOCK_WIDE      = 12,
  parameter int UNLOCK_WIDE    = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             refEdge,
  input  logic             fbEdge,
  input  logic             windowSel,
  input  logic [1:0]       backlashCode,
  input  logic [GAP_W-1:0] pairTimeout,
  output gap_evt_t         evt,
  output logic [GAP_W-1:0] phaseGap
);

  localparam logic [GAP_W-1:0] GAP_SAT = '1;

  pend_e            pend;
  logic [GAP_W-1:0] elapsed;
  logic [GAP_W-1:0] lockTh, unlockTh;
  logic             partner, timedOut, measured;
  logic [GAP_W-1:0] gapNow;

  always_comb begin
    lockTh   = (windowSel ? GAP_W'(LOCK_WIDE)   : GAP_W'(LOCK_NARROW))   + GAP_W'(backlashCode);
    unlockTh = (windowSel ? GAP_W'(UNLOCK_WIDE) : GAP_W'(UNLOCK_NARROW)) + GAP_W'(backlashCode);
  end

  always_comb begin
    partner  = (pend == PEND_REF && fbEdge) || (pend == PEND_FB && refEdge);
    timedOut = (pend != PEND_NONE) && !partner && (elapsed >= pairTimeout);
    measured = partner || (pend == PEND_NONE && refEdge && fbEdge);
    gapNow   = (pend == PEND_NONE) ? '0 : elapsed;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend     <= PEND_NONE;
      elapsed  <= '0;
      evt      <= '0;
      phaseGap <= '0;
    end else begin
      evt <= '0;
      if (measured) begin
        pend      <= PEND_NONE;
        phaseGap  <= gapNow;
        evt.good  <= (gapNow < lockTh);
        evt.bad   <= (gapNow > unlockTh);
        evt.mid   <= (gapNow >= lockTh) && (gapNow <= unlockTh);
      end else if (timedOut) begin
        pend     <= PEND_NONE;
        phaseGap <= GAP_SAT;
        evt.bad  <= 1'b1;
      end else if (pend == PEND_NONE) begin
        if (refEdge) begin
          pend    <= PEND_REF;
          elapsed <= GAP_W'(1);
        end else if (fbEdge) begin
          pend    <= PEND_FB;
          elapsed <= GAP_W'(1);
        end
      end else begin
        elapsed <= elapsed + GAP_W'(1);
      end
    end
  end

  // R2: coincident edges from idle give a zero gap and leave nothing pending
  p_coincident_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (pend == PEND_NONE && refEdge && fbEdge) |=> (phaseGap == '0 && pend == PEND_NONE));

  // R3: a waiting reference edge survives more reference strobes
  p_same_side_ignored_r3: assert property (@(posedge clk) disable iff (rst)
    (pend == PEND_REF && !fbEdge && elapsed < pairTimeout) |=> (pend == PEND_REF));

  // R9: an expired wait yields a bad cycle with a saturated gap
  p_timeout_bad_r9: assert property (@(posedge clk) disable iff (rst)
    (pend != PEND_NONE && !partner && elapsed >= pairTimeout)
      |=> (evt.bad && phaseGap == GAP_SAT && pend == PEND_NONE));

  // R4: at most one class per measurement
  p_one_class_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({evt.good, evt.mid, evt.bad}));

endmodule

// File: rtl/plm_control.sv
module plm_control
  import plm_pkg::*;
#(
  parameter int RUN_W = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  gap_evt_t   evt,
  input  logic [1:0] countCode,
  output logic       locked
);

  logic [RUN_W-1:0] run;
  logic [RUN_W:0]   runNext;
  logic [RUN_W:0]   need;

  always_comb begin
    runNext = {1'b0, run} + 1'b1;
    need    = (RUN_W+1)'(runTarget(countCode));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      locked <= 1'b0;
      run    <= '0;
    end else if (evt.bad) begin
      locked <= 1'b0;
      run    <= '0;
    end else if (evt.mid) begin
      run <= '0;
    end else if (evt.good && !locked) begin
      if (runNext >= need) begin
        locked <= 1'b1;
        run    <= '0;
      end else begin
        run <= runNext[RUN_W-1:0];
      end
    end
  end

  // R8: one bad cycle drops lock
  p_drop_on_bad_r8: assert property (@(posedge clk) disable iff (rst)
    evt.bad |=> !locked);

  // R7: lock holds through anything but a bad cycle
  p_hold_lock_r7: assert property (@(posedge clk) disable iff (rst)
    (locked && !evt.bad) |=> locked);

  // R5: lock can only rise on a good cycle
  p_rise_needs_good_r5: assert property (@(posedge clk) disable iff (rst)
    (!locked && !evt.good) |=> !locked);

  // R6: a neutral or bad cycle restarts the run
  p_run_restart_r6: assert property (@(posedge clk) disable iff (rst)
    (evt.mid || evt.bad) |=> (run == '0));

endmodule

// File: rtl/phase_lock_monitor.sv
module phase_lock_monitor
  import plm_pkg::*;
#(
  parameter int GAP_W = 16,
  parameter int RUN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             refEdge,
  input  logic             fbEdge,
  input  logic             windowSel,
  input  logic [1:0]       backlashCode,
  input  logic [1:0]       countCode,
  input  logic [GAP_W-1:0] pairTimeout,
  output logic             locked,
  output logic [GAP_W-1:0] phaseGap
);

  gap_evt_t evt;

  plm_datapath #(.GAP_W(GAP_W)) i_datapath (
    .clk(clk), .rst(rst), .refEdge(refEdge), .fbEdge(fbEdge),
    .windowSel(windowSel), .backlashCode(backlashCode),
    .pairTimeout(pairTimeout), .evt(evt), .phaseGap(phaseGap)
  );

  plm_control #(.RUN_W(RUN_W)) i_control (
    .clk(clk), .rst(rst), .evt(evt), .countCode(countCode), .locked(locked)
  );

  // R10: lock changes only one cycle after a classified measurement
  p_lock_follows_evt_r10: assert property (@(posedge clk) disable iff (rst)
    (!$past(evt.good) && !$past(evt.bad) && !$past(rst)) |-> $stable(locked));

endmodule

// File: tb/test_phase_lock_monitor.sv
module test_phase_lock_monitor;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        refEdge = 1'b0, fbEdge = 1'b0, windowSel = 1'b0;
  logic [1:0]  backlashCode = 2'd0, countCode = 2'd0;
  logic [15:0] pairTimeout = 16'd1000;
  logic        locked;
  logic [15:0] phaseGap;

  int checks = 0, failures = 0;
  bit started = 1'b0, finished = 1'b0;

  // reference model state
  int mPend = 0, mEl = 0, mGap = 0, mEvt = 0, mLocked = 0, mRun = 0;

  always #10 clk = ~clk;

  phase_lock_monitor i_phase_lock_monitor (
    .clk(clk), .rst(rst), .refEdge(refEdge), .fbEdge(fbEdge),
    .windowSel(windowSel), .backlashCode(backlashCode), .countCode(countCode),
    .pairTimeout(pairTimeout), .locked(locked), .phaseGap(phaseGap)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int needOf(input int code);
    case (code)
      0: return 5;
      1: return 16;
      2: return 64;
      default: return 255;
    endcase
  endfunction

  // behavioural reference, one step per clock
  always @(posedge clk) begin
    int g, lt, ut, ev;
    if (rst) begin
      mPend = 0; mEl = 0; mGap = 0; mEvt = 0; mLocked = 0; mRun = 0;
    end else begin
      if (mEvt == 3) begin mLocked = 0; mRun = 0; end
      else if (mEvt == 2) mRun = 0;
      else if (mEvt == 1 && mLocked == 0) begin
        if (mRun + 1 >= needOf(int'(countCode))) begin mLocked = 1; mRun = 0; end
        else mRun++;
      end
      g = -1;
      if (mPend == 0) begin
        if (refEdge && fbEdge) g = 0;
        else if (refEdge) begin mPend = 1; mEl = 1; end
        else if (fbEdge) begin mPend = 2; mEl = 1; end
      end else if ((mPend == 1 && fbEdge) || (mPend == 2 && refEdge)) begin
        g = mEl; mPend = 0;
      end else if (mEl >= int'(pairTimeout)) begin
        g = -2; mPend = 0;
      end else mEl++;
      ev = 0;
      if (g == -2) begin mGap = 65535; ev = 3; end
      else if (g >= 0) begin
        lt = (windowSel ? 12 : 4) + int'(backlashCode);
        ut = (windowSel ? 24 : 8) + int'(backlashCode);
        mGap = g;
        ev = (g < lt) ? 1 : ((g > ut) ? 3 : 2);
      end
      mEvt = ev;
    end
    started = 1'b1;
  end

  // R10 / R2: every-cycle comparison against the model
  always @(negedge clk) begin
    if (started && !finished) begin
      chk("R10 locked vs model", int'(locked), mLocked);
      chk("R2 phaseGap vs model", int'(phaseGap), mGap);
    end
  end

  // one PFD period: d>=0 reference first, d<0 feedback first
  task automatic pfd(input int d, input int period);
    int refAt = (d >= 0) ? 0 : -d;
    int fbAt  = (d >= 0) ? d : 0;
    for (int c = 0; c < period; c++) begin
      @(negedge clk);
      refEdge = (c == refAt);
      fbEdge  = (c == fbAt);
    end
    @(negedge clk);
    refEdge = 1'b0; fbEdge = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      refEdge = 1'b0; fbEdge = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 locked after reset", int'(locked), 0);
    chk("R1 phaseGap after reset", int'(phaseGap), 0);

    // R5: narrow window, 5 good cycles
    for (int i = 0; i < 4; i++) pfd(2, 12);
    chk("R5 not yet locked after 4 good", int'(locked), 0);
    chk("R2 gap of 2", int'(phaseGap), 2);
    // R10: watch the fifth pair edge by edge
    @(negedge clk); refEdge = 1'b1;
    @(negedge clk); refEdge = 1'b0;
    @(negedge clk); fbEdge = 1'b1;
    @(negedge clk); fbEdge = 1'b0;
    chk("R10 gap due one cycle after partner", int'(phaseGap), 2);
    chk("R10 lock not yet with gap", int'(locked), 0);
    @(negedge clk);
    chk("R10 lock one cycle after gap", int'(locked), 1);
    idle(8);

    // R7: neutral gaps keep lock, including unlock threshold itself
    pfd(6, 12);
    chk("R7 neutral gap keeps lock", int'(locked), 1);
    pfd(8, 12);
    chk("R7 gap equal unlock keeps lock", int'(locked), 1);
    pfd(-4, 12);
    chk("R7 gap equal lock keeps lock", int'(locked), 1);
    chk("R2 feedback-first gap", int'(phaseGap), 4);
    // R8: one bad cycle
    pfd(9, 14);
    chk("R8 single bad cycle drops lock", int'(locked), 0);

    // R6: neutral cycle restarts run
    for (int i = 0; i < 4; i++) pfd(3, 10);
    pfd(5, 10);
    for (int i = 0; i < 4; i++) pfd(3, 10);
    chk("R6 neutral restarts run", int'(locked), 0);
    pfd(3, 10);
    chk("R6 lock after fresh run", int'(locked), 1);

    // R2: coincident edges
    pfd(0, 10);
    chk("R2 coincident gap zero", int'(phaseGap), 0);

    // R3: repeated reference strobes while waiting
    @(negedge clk); refEdge = 1'b1;
    @(negedge clk); refEdge = 1'b0;
    @(negedge clk); refEdge = 1'b1;
    @(negedge clk); refEdge = 1'b0;
    @(negedge clk);
    @(negedge clk); fbEdge = 1'b1;
    @(negedge clk); fbEdge = 1'b0;
    idle(3);
    chk("R3 gap from first reference", int'(phaseGap), 5);
    chk("R3 lock kept (gap 5 neutral)", int'(locked), 1);

    // R9: missing partner
    pairTimeout = 16'd20;
    @(negedge clk); refEdge = 1'b1;
    @(negedge clk); refEdge = 1'b0;
    idle(25);
    chk("R9 timeout gap saturated", int'(phaseGap), 65535);
    chk("R9 timeout drops lock", int'(locked), 0);
    pfd(-2, 10);
    chk("R9 pending cleared after timeout", int'(phaseGap), 2);
    pairTimeout = 16'd1000;

    // R4: wide window, backlash 3: lock 15, unlock 27
    windowSel = 1'b1; backlashCode = 2'd3;
    for (int i = 0; i < 5; i++) pfd(14, 40);
    chk("R4 gap 14 is good", int'(locked), 1);
    pfd(15, 40);
    pfd(27, 40);
    chk("R4 gap 27 neutral keeps lock", int'(locked), 1);
    pfd(28, 40);
    chk("R4 gap 28 drops lock", int'(locked), 0);
    for (int i = 0; i < 4; i++) pfd(14, 40);
    pfd(15, 40);
    pfd(14, 40);
    chk("R4 gap 15 is not good", int'(locked), 0);
    windowSel = 1'b0; backlashCode = 2'd0;

    // R5: every run length code
    for (int code = 0; code < 4; code++) begin
      countCode = 2'(code);
      pfd(20, 30);
      for (int i = 0; i < needOf(code) - 1; i++) pfd(1, 8);
      chk($sformatf("R5 code %0d one short", code), int'(locked), 0);
      pfd(1, 8);
      chk($sformatf("R5 code %0d locked", code), int'(locked), 1);
    end

    // R1: reset mid-lock with an edge waiting
    @(negedge clk); refEdge = 1'b1;
    @(negedge clk); refEdge = 1'b0; rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 reset clears lock", int'(locked), 0);
    chk("R1 reset clears gap", int'(phaseGap), 0);
    pfd(-3, 10);
    chk("R1 stale edge discarded", int'(phaseGap), 3);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule